// File: doc/BRIEF.md
# USB Endpoint Stall Control

This block decides, for every transaction a USB device controller receives from the host, whether the addressed endpoint answers with a stall handshake or accepts the transaction. It keeps two separate per-endpoint states: a halt flag that only the host can clear, and a stall-request bit that software writes.

A request bit does nothing at the moment it is written. It turns into a halt only when a transaction reaches that endpoint while the endpoint's halt flag is clear. When the auto-clear option is on, that same event also drops the request bit. If the request bit is still set after the host clears the halt with Clear Feature (endpoint halt), the next transaction sets the halt again. A stall therefore ends only when both the request bit and the halt flag are clear. A setup packet clears the halt flag of endpoint 0.

The decision is registered. It appears one cycle after the transaction strobe, together with the endpoint number it belongs to.

Top module: `ep_stall_ctrl`

## Requirements
- R1: After reset, all halt flags and all request bits are 0 and the auto-clear option is off. A transaction to any endpoint is then accepted.
- R2: Writing the request register never sets or clears a halt flag. If a request bit is written to 1 and then back to 0 before any transaction reaches that endpoint, the next transaction is accepted.
- R3: When a transaction arrives with the endpoint's halt flag clear and its request bit set, the decision is stall and the halt flag becomes set.
- R4: When a transaction arrives with both the halt flag and the request bit clear, the decision is accept and the halt flag stays clear.
- R5: When a request-driven stall happens with auto-clear on, the endpoint's request bit reads 0 in the cycle after the transaction. With auto-clear off, the bit is kept. A stall caused by an already-set halt flag leaves the request bit unchanged.
- R6: A set halt flag makes every transaction to that endpoint a stall, whatever the request register holds.
- R7: Only a Clear Feature addressed to an endpoint clears that endpoint's halt flag. Software writes do not, and other endpoints are not affected.
- R8: After a Clear Feature, if the endpoint's request bit is still 1, the next transaction stalls and sets the halt again. If the request bit is 0, the next transaction is accepted.
- R9: A setup strobe clears the halt flag of endpoint 0 and of no other endpoint.
- R10: When a software write and an auto-clear hit the same request bit in the same cycle, the bit ends at 0. Other bits take the written value.
- R11: A Clear Feature (or, for endpoint 0, a setup) in the same cycle as a transaction to the same endpoint is applied first. The transaction is then judged on the request bit alone.
- R12: dec_valid_o pulses exactly one cycle after txn_valid_i. dec_ep_o repeats the endpoint number, and dec_stall_o is 1 for stall and 0 for accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_req_we_i | input | 1 | Write strobe for the stall-request register |
| sw_req_wdata_i | input | NUM_EP | New stall-request bits, one per endpoint |
| sw_cfg_we_i | input | 1 | Write strobe for the auto-clear option |
| sw_auto_clr_i | input | 1 | New auto-clear option value |
| txn_valid_i | input | 1 | A host transaction arrived |
| txn_ep_i | input | EPW | Endpoint number of the transaction |
| clr_feat_i | input | 1 | Host Clear Feature (endpoint halt) strobe |
| clr_feat_ep_i | input | EPW | Endpoint number of the Clear Feature |
| setup_i | input | 1 | Setup packet received on endpoint 0 |
| dec_valid_o | output | 1 | Decision valid, one cycle after txn_valid_i |
| dec_stall_o | output | 1 | 1 = stall handshake, 0 = accept |
| dec_ep_o | output | EPW | Endpoint number the decision belongs to |
| req_o | output | NUM_EP | Current stall-request register |
| auto_clr_en_o | output | 1 | Current auto-clear option |

## Verification
The bench builds the block with NUM_EP = 4. With so few endpoints, a long pseudo-random stream of transactions, Clear Features, setups and register writes regularly lands on the same endpoint in the same cycle. That brings the collision orderings of R10 and R11, and the endpoint-0 setup clear, into frequent reach. A bench-side model of halt and request state predicts each decision and each request-register value. Directed sequences walk through the full stall life cycle: arm, re-arm after Clear Feature, and release.

// File: rtl/ep_stall_pkg.sv
package ep_stall_pkg;
  typedef enum logic {
    DEC_ACCEPT = 1'b0,
    DEC_STALL  = 1'b1
  } dec_e;
endpackage

// File: rtl/ep_stall_req_reg.sv
module ep_stall_req_reg #(
  parameter int NUM_EP = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NUM_EP-1:0] wdata_i,
  input  logic              cfg_we_i,
  input  logic              cfg_auto_i,
  input  logic [NUM_EP-1:0] auto_clr_i,
  output logic [NUM_EP-1:0] req_o,
  output logic              auto_en_o
);
  logic [NUM_EP-1:0] req_q;
  logic              auto_q;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            req_q[e] <= 1'b0;
      else if (auto_clr_i[e]) req_q[e] <= 1'b0;  // auto-clear beats write
      else if (we_i)          req_q[e] <= wdata_i[e];
    end

    // R10
    req_autoclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      auto_clr_i[e] |=> !req_q[e]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       auto_q <= 1'b0;
    else if (cfg_we_i) auto_q <= cfg_auto_i;
  end

  assign req_o     = req_q;
  assign auto_en_o = auto_q;
endmodule

// File: rtl/ep_stall_halt.sv
module ep_stall_halt #(
  parameter int NUM_EP = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EP-1:0] clr_i,
  input  logic [NUM_EP-1:0] set_i,
  output logic [NUM_EP-1:0] halt_eff_o
);
  logic [NUM_EP-1:0] halt_q;

  // clear is applied before the transaction in the same cycle
  assign halt_eff_o = halt_q & ~clr_i;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) halt_q[e] <= 1'b0;
      else         halt_q[e] <= halt_eff_o[e] | set_i[e];
    end

    // R6
    halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      halt_q[e] && !clr_i[e] |=> halt_q[e]);
    // R2
    halt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !halt_q[e] && !set_i[e] |=> !halt_q[e]);
  end
endmodule

// File: rtl/ep_stall_decide.sv
module ep_stall_decide
  import ep_stall_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int EPW    = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_valid_i,
  input  logic [EPW-1:0]    txn_ep_i,
  input  logic [NUM_EP-1:0] halt_eff_i,
  input  logic [NUM_EP-1:0] req_i,
  input  logic              auto_en_i,
  output logic [NUM_EP-1:0] set_o,
  output logic [NUM_EP-1:0] auto_clr_o,
  output logic              dec_valid_o,
  output logic              dec_stall_o,
  output logic [EPW-1:0]    dec_ep_o
);
  logic halt_sel, req_sel, req_hit;
  dec_e dec_d;

  assign halt_sel = halt_eff_i[txn_ep_i];
  assign req_sel  = req_i[txn_ep_i];
  assign req_hit  = txn_valid_i && !halt_sel && req_sel;
  assign dec_d    = (halt_sel || req_sel) ? DEC_STALL : DEC_ACCEPT;

  always_comb begin
    set_o      = '0;
    auto_clr_o = '0;
    set_o[txn_ep_i]      = req_hit;
    auto_clr_o[txn_ep_i] = req_hit && auto_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      dec_stall_o <= 1'b0;
      dec_ep_o    <= '0;
    end else begin
      dec_valid_o <= txn_valid_i;
      if (txn_valid_i) begin
        dec_stall_o <= dec_d;
        dec_ep_o    <= txn_ep_i;
      end
    end
  end

  // R12
  dec_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_i |=> dec_valid_o && dec_ep_o == $past(txn_ep_i));
  // R12
  dec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txn_valid_i |=> !dec_valid_o);
  // R5
  autoclr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(auto_clr_o) && ((auto_clr_o & ~set_o) == '0));
endmodule

// File: rtl/ep_stall_ctrl.sv
module ep_stall_ctrl #(
  parameter int NUM_EP = 16,
  parameter int EPW    = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_req_we_i,
  input  logic [NUM_EP-1:0] sw_req_wdata_i,
  input  logic              sw_cfg_we_i,
  input  logic              sw_auto_clr_i,
  input  logic              txn_valid_i,
  input  logic [EPW-1:0]    txn_ep_i,
  input  logic              clr_feat_i,
  input  logic [EPW-1:0]    clr_feat_ep_i,
  input  logic              setup_i,
  output logic              dec_valid_o,
  output logic              dec_stall_o,
  output logic [EPW-1:0]    dec_ep_o,
  output logic [NUM_EP-1:0] req_o,
  output logic              auto_clr_en_o
);
  logic [NUM_EP-1:0] clr_vec, set_vec, auto_clr_vec, halt_eff, req_q;
  logic              auto_en;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_clr
    if (e == 0) begin : g_ep0
      assign clr_vec[e] = (clr_feat_i && clr_feat_ep_i == EPW'(e)) || setup_i;
    end else begin : g_epn
      assign clr_vec[e] = clr_feat_i && clr_feat_ep_i == EPW'(e);
    end
  end

  ep_stall_req_reg #(.NUM_EP(NUM_EP)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (sw_req_we_i),
    .wdata_i    (sw_req_wdata_i),
    .cfg_we_i   (sw_cfg_we_i),
    .cfg_auto_i (sw_auto_clr_i),
    .auto_clr_i (auto_clr_vec),
    .req_o      (req_q),
    .auto_en_o  (auto_en)
  );

  ep_stall_halt #(.NUM_EP(NUM_EP)) u_halt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_vec),
    .set_i      (set_vec),
    .halt_eff_o (halt_eff)
  );

  ep_stall_decide #(.NUM_EP(NUM_EP), .EPW(EPW)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .txn_valid_i (txn_valid_i),
    .txn_ep_i    (txn_ep_i),
    .halt_eff_i  (halt_eff),
    .req_i       (req_q),
    .auto_en_i   (auto_en),
    .set_o       (set_vec),
    .auto_clr_o  (auto_clr_vec),
    .dec_valid_o (dec_valid_o),
    .dec_stall_o (dec_stall_o),
    .dec_ep_o    (dec_ep_o)
  );

  assign req_o         = req_q;
  assign auto_clr_en_o = auto_en;

  // R9
  setup_ep0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i |-> !halt_eff[0]);
  // R1
  rst_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> req_q == '0 && !auto_en);
endmodule

// File: tb/ep_stall_ctrl_tb_top.sv
`timescale 1ns/1ps
module ep_stall_ctrl_tb_top;
  localparam int NE = 4;
  localparam int EW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_we = 1'b0, cfg_we = 1'b0, cfg_val = 1'b0;
  logic [NE-1:0] req_wd = '0;
  logic txn_v = 1'b0, clr_v = 1'b0, setup = 1'b0;
  logic [EW-1:0] txn_ep = '0, clr_ep = '0;
  logic dec_valid, dec_stall, auto_en;
  logic [EW-1:0] dec_ep;
  logic [NE-1:0] req_q;

  int checks = 0;
  int errors = 0;
  logic [NE-1:0] m_halt = '0;
  logic [NE-1:0] m_req = '0;
  logic m_auto = 1'b0;

  always #5 clk = ~clk;

  ep_stall_ctrl #(.NUM_EP(NE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .sw_req_we_i(req_we), .sw_req_wdata_i(req_wd),
    .sw_cfg_we_i(cfg_we), .sw_auto_clr_i(cfg_val),
    .txn_valid_i(txn_v), .txn_ep_i(txn_ep),
    .clr_feat_i(clr_v), .clr_feat_ep_i(clr_ep), .setup_i(setup),
    .dec_valid_o(dec_valid), .dec_stall_o(dec_stall), .dec_ep_o(dec_ep),
    .req_o(req_q), .auto_clr_en_o(auto_en)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one cycle: drive at negedge, check at the following negedge
  task automatic step(input logic tv, input logic [EW-1:0] te,
                      input logic cv, input logic [EW-1:0] ce, input logic su,
                      input logic we, input logic [NE-1:0] wd,
                      input logic cw, input logic cval, input string tag);
    logic [NE-1:0] h, r;
    logic exp_stall, ac, was_halt;
    string t, rt;
    txn_v = tv; txn_ep = te; clr_v = cv; clr_ep = ce; setup = su;
    req_we = we; req_wd = wd; cfg_we = cw; cfg_val = cval;
    h = m_halt;
    if (cv) h[ce] = 1'b0;
    if (su) h[0] = 1'b0;
    was_halt = h[te];
    exp_stall = 1'b0; ac = 1'b0;
    if (tv) begin
      if (h[te]) exp_stall = 1'b1;
      else if (m_req[te]) begin
        exp_stall = 1'b1; h[te] = 1'b1; ac = m_auto;
      end
    end
    r = we ? wd : m_req;
    if (ac) r[te] = 1'b0;
    t = tag;
    if (t == "") begin
      if (tv && cv && ce == te) t = "R11";
      else if (tv && su && te == 0) t = "R9";
      else if (was_halt) t = "R6";
      else if (m_req[te]) t = "R3";
      else t = "R4";
    end
    rt = (ac && we && wd[te]) ? "R10" : "R5";
    m_halt = h; m_req = r;
    if (cw) m_auto = cval;
    @(negedge clk);
    txn_v = 1'b0; clr_v = 1'b0; setup = 1'b0; req_we = 1'b0; cfg_we = 1'b0;
    chk(dec_valid == tv, "R12", "dec_valid", int'(dec_valid), int'(tv));
    if (tv) begin
      chk(dec_ep == te, "R12", "dec_ep", int'(dec_ep), int'(te));
      chk(dec_stall == exp_stall, t, "dec_stall", int'(dec_stall), int'(exp_stall));
    end
    chk(req_q == m_req, rt, "req", int'(req_q), int'(m_req));
    chk(auto_en == m_auto, "R5", "auto_en", int'(auto_en), int'(m_auto));
  endtask

  task automatic wr(input logic [NE-1:0] v);
    step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, v, 1'b0, 1'b0, "R2");
  endtask
  task automatic tx(input logic [EW-1:0] e, input string tag);
    step(1'b1, e, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask
  task automatic cf(input logic [EW-1:0] e);
    step(1'b0, '0, 1'b1, e, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R7");
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_q == '0, "R1", "req after reset", int'(req_q), 0);
    chk(auto_en == 1'b0, "R1", "auto_en after reset", int'(auto_en), 0);
    chk(dec_valid == 1'b0, "R1", "dec_valid after reset", int'(dec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int e = 0; e < NE; e++) tx(EW'(e), "R1");
    // R2: write and withdraw before any transaction
    wr(4'b0010); wr(4'b0000); tx(2'd1, "R2");
    // R3 with auto-clear off: request kept (R5)
    wr(4'b0010); tx(2'd1, "R3");
    // R6/R7: software clearing request does not end the halt
    wr(4'b0000); tx(2'd1, "R6"); tx(2'd1, "R7");
    // R8: request still set re-arms after Clear Feature
    wr(4'b0010); cf(2'd1); tx(2'd1, "R8");
    wr(4'b0000); cf(2'd1); tx(2'd1, "R8"); tx(2'd1, "R7");
    // R5: auto-clear on
    step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b1, "R5");
    wr(4'b0100); tx(2'd2, "R5"); tx(2'd2, "R6"); cf(2'd2); tx(2'd2, "R8");
    // R7: Clear Feature on another endpoint leaves halt
    wr(4'b1000); tx(2'd3, "R3"); cf(2'd1); tx(2'd3, "R7");
    // R10: write and auto-clear same bit same cycle
    wr(4'b0001);
    step(1'b1, 2'd0, 1'b0, '0, 1'b0, 1'b1, 4'b0011, 1'b0, 1'b0, "R10");
    // R9: setup clears ep0 only
    step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R9");
    tx(2'd3, "R9");
    wr(4'b0000);
    tx(2'd0, "R9");
    // R11: clear and transaction same cycle
    step(1'b1, 2'd3, 1'b1, 2'd3, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R11");
    wr(4'b0010); tx(2'd1, "R3");
    step(1'b1, 2'd1, 1'b1, 2'd1, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R11");
    // pseudo-random sweep
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], r[6:4] == 3'd0, r[8:7], r[11:9] == 3'd0,
           r[14:12] == 3'd0, r[18:15], r[23:20] == 4'd0, r[24], "");
    end
    finish_run();
  end
endmodule